// File: doc/BRIEF.md
# Two-Check-Symbol Reed-Solomon Row Encoder

This block turns a row of data symbols, one symbol per storage component, into a systematic Reed-Solomon codeword by appending two check symbols. Symbols are 8-bit elements of GF(2^8), built on the field polynomial x^8+x^4+x^3+x^2+1 with alpha = 0x02. The generator is g(x) = (x + alpha^0)(x + alpha^1) = x^2 + 0x03·x + 0x02. Any finished row is therefore a multiple of g(x), and it evaluates to zero at both 1 and alpha. The first of these two checks is a plain XOR across the whole row.

Data arrives as one symbol per clock, qualified by a valid strobe. A first-of-row flag marks the opening symbol and a last-of-row flag marks the closing one. The block divides by g(x) one symbol at a time, highest-degree symbol first. In the cycle after the closing symbol it raises a one-cycle done pulse. At the same time it presents the higher-degree check symbol (coefficient of x^1) and the lower-degree check symbol (coefficient of x^0). These are stored in the two redundant components of the row. The check outputs hold their value until the next row completes.

Top module: `rs_row_encoder`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, par_done is 0 and par_hi and par_lo are both 0x00.
- R2: par_done is 1 exactly in the cycle that follows a clock edge at which in_valid and in_last were both 1. In every other cycle it is 0.
- R3: When par_done is 1, the XOR of all data symbols of the row together with par_hi and par_lo equals 0x00. This is the root alpha^0.
- R4: When par_done is 1, the row polynomial D(x)·x^2 + par_hi·x + par_lo evaluates to 0x00 at x = alpha = 0x02. The first data symbol is the highest-degree coefficient.
- R5: par_hi and par_lo are the x^1 and x^0 coefficients of the remainder of D(x)·x^2 divided by g(x) = x^2 + 0x03·x + 0x02. For example, the single symbol 0x01 gives 0x03/0x02, 0x80 gives 0x9D/0x1D, and the two-symbol row 0x01,0x00 gives 0x07/0x06.
- R6: A symbol accepted with in_first = 1 begins from cleared check state. Any earlier row, including one abandoned without a last flag, has no effect on the new row's check symbols.
- R7: Cycles with in_valid = 0 leave the division state unchanged, whatever values in_sym, in_first and in_last carry in those cycles.
- R8: par_hi and par_lo change only in a cycle where par_done is 1. Otherwise they hold their previous value, including while a later row is being streamed.
- R9: Leading zero data symbols do not change the check symbols. For example, 0x00,0x00,0x01,0x00 gives the same result as 0x01,0x00.
- R10: Rows of 1 to 253 data symbols are encoded correctly. A row never counts more than 253 accepted symbols.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies in_sym, in_first and in_last |
| in_first | input | 1 | Marks the first data symbol of a row |
| in_last | input | 1 | Marks the last data symbol of a row |
| in_sym | input | 8 | Data symbol, highest-degree first |
| par_done | output | 1 | One-cycle pulse: check symbols are valid |
| par_hi | output | 8 | Check symbol, coefficient of x^1 |
| par_lo | output | 8 | Check symbol, coefficient of x^0 |

## Verification
The division state lives in two 8-bit registers, so a wrong value in either one is not visible until the row ends. It then shows up at par_done as a nonzero XOR syndrome, a nonzero syndrome at alpha, or both. A fault in the first-of-row clear shows up in the first row that follows any nonzero row. A fault in the valid gating shows up in the first row that has idle gaps. A stuck bit in the feedback multiplier is caught by single-symbol rows, whose check symbols are simply 0x03·d and 0x02·d.

// File: rtl/rsenc_pkg.sv
package rsenc_pkg;
  localparam int SYM_W = 8;
  localparam int NPAR  = 2;
  localparam logic [SYM_W:0]   FIELD_POLY = 9'h11D;
  localparam logic [SYM_W-1:0] ALPHA      = 8'h02;

  typedef logic [SYM_W-1:0] sym_t;
  typedef sym_t [NPAR:0]    gpoly_t;

  // multiply by x modulo the field polynomial
  function automatic sym_t gf_xtime(input sym_t a);
    sym_t r;
    r = {a[SYM_W-2:0], 1'b0};
    if (a[SYM_W-1]) r = r ^ FIELD_POLY[SYM_W-1:0];
    return r;
  endfunction

  // general field product, lsb-first shift and add
  function automatic sym_t gf_mul(input sym_t a, input sym_t b);
    sym_t p;
    sym_t s;
    p = '0;
    s = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) p = p ^ s;
      s = gf_xtime(s);
    end
    return p;
  endfunction

  // product of (x + alpha^j), j = 0 .. NPAR-1; index k holds coefficient of x^k
  function automatic gpoly_t gen_poly();
    gpoly_t g;
    sym_t   root;
    g    = '0;
    g[0] = sym_t'(1);
    root = sym_t'(1);
    for (int j = 0; j < NPAR; j++) begin
      for (int k = NPAR; k > 0; k--) g[k] = g[k-1] ^ gf_mul(g[k], root);
      g[0] = gf_mul(g[0], root);
      root = gf_mul(root, ALPHA);
    end
    return g;
  endfunction

  localparam gpoly_t GEN = gen_poly();
endpackage

// File: rtl/rsenc_gf_cmul.sv
module rsenc_gf_cmul
  import rsenc_pkg::*;
#(
  parameter sym_t COEF = sym_t'(1)
) (
  input  sym_t x,
  output sym_t y
);
  assign y = gf_mul(x, COEF);
endmodule

// File: rtl/rsenc_lfsr.sv
module rsenc_lfsr
  import rsenc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                clear,
  input  sym_t                din,
  output sym_t [NPAR-1:0]     state_nxt
);
  sym_t [NPAR-1:0] state_q;
  sym_t [NPAR-1:0] base;
  sym_t [NPAR-1:0] prod;
  sym_t            fb;

  assign base = clear ? '0 : state_q;
  assign fb   = din ^ base[NPAR-1];

  for (genvar j = 0; j < NPAR; j++) begin : g_tap
    rsenc_gf_cmul #(.COEF(GEN[j])) u_mul (.x(fb), .y(prod[j]));
    if (j == 0) begin : g_low
      assign state_nxt[j] = prod[j];
    end else begin : g_up
      assign state_nxt[j] = base[j-1] ^ prod[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= '0;
    else if (shift_en) state_q <= state_nxt;
  end
endmodule

// File: rtl/rsenc_row_ctrl.sv
module rsenc_row_ctrl #(
  parameter int MAX_ROW = 253
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic                           in_first,
  input  logic                           in_last,
  output logic                           row_start,
  output logic                           row_end,
  output logic                           shift_en,
  output logic                           done_q,
  output logic [$clog2(MAX_ROW+2)-1:0]   row_len
);
  localparam int CNT_W = $clog2(MAX_ROW + 2);

  assign shift_en  = in_valid;
  assign row_start = in_valid && in_first;
  assign row_end   = in_valid && in_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      row_len <= '0;
    end else begin
      done_q <= row_end;
      if (row_start)
        row_len <= CNT_W'(1);
      else if (in_valid && (row_len <= CNT_W'(MAX_ROW)))
        row_len <= row_len + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rs_row_encoder.sv
module rs_row_encoder
  import rsenc_pkg::*;
#(
  parameter int MAX_ROW = 253
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             in_last,
  input  logic [SYM_W-1:0] in_sym,
  output logic             par_done,
  output logic [SYM_W-1:0] par_hi,
  output logic [SYM_W-1:0] par_lo
);
  localparam int CNT_W = $clog2(MAX_ROW + 2);

  logic                 row_start;
  logic                 row_end;
  logic                 shift_en;
  logic [CNT_W-1:0]     row_len;
  sym_t [NPAR-1:0]      state_nxt;

  rsenc_row_ctrl #(.MAX_ROW(MAX_ROW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
    .row_start(row_start), .row_end(row_end), .shift_en(shift_en),
    .done_q(par_done), .row_len(row_len)
  );

  rsenc_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n),
    .shift_en(shift_en), .clear(row_start), .din(in_sym),
    .state_nxt(state_nxt)
  );

  // check symbols captured as the last data symbol is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_hi <= '0;
      par_lo <= '0;
    end else if (row_end) begin
      par_hi <= state_nxt[NPAR-1];
      par_lo <= state_nxt[0];
    end
  end
endmodule

// File: rtl/rs_row_encoder_chk.sv
module rs_row_encoder_chk
  import rsenc_pkg::*;
#(
  parameter int MAX_ROW = 253,
  parameter int CNT_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_first,
  input logic             in_last,
  input logic [SYM_W-1:0] in_sym,
  input logic             par_done,
  input logic [SYM_W-1:0] par_hi,
  input logic [SYM_W-1:0] par_lo,
  input logic [CNT_W-1:0] row_len
);
  // independent syndrome accumulators: plain XOR and Horner evaluation at alpha
  sym_t acc_x, acc_h;
  sym_t bx, bh;
  assign bx = in_first ? '0 : acc_x;
  assign bh = in_first ? '0 : acc_h;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_x <= '0;
      acc_h <= '0;
    end else if (in_valid) begin
      acc_x <= bx ^ in_sym;
      acc_h <= gf_mul(bh, ALPHA) ^ in_sym;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!par_done && par_hi == '0 && par_lo == '0));

  assert_done_follows_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> par_done);

  assert_done_only_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    par_done |-> $past(in_valid && in_last));

  assert_xor_syndrome_R3: assert property (@(posedge clk) disable iff (!rst_n)
    par_done |-> ((acc_x ^ par_hi ^ par_lo) == '0));

  assert_alpha_syndrome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    par_done |-> ((gf_mul(acc_h, gf_mul(ALPHA, ALPHA)) ^ gf_mul(par_hi, ALPHA) ^ par_lo) == '0));

  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !par_done |-> ($stable(par_hi) && $stable(par_lo)));

  assert_row_length_R10: assert property (@(posedge clk) disable iff (!rst_n)
    row_len <= CNT_W'(MAX_ROW));
endmodule

bind rs_row_encoder rs_row_encoder_chk #(.MAX_ROW(MAX_ROW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
  .in_last(in_last), .in_sym(in_sym), .par_done(par_done),
  .par_hi(par_hi), .par_lo(par_lo), .row_len(row_len)
);

// File: tb/tb_rs_row_encoder.sv
`timescale 1ns/1ps
module tb_rs_row_encoder;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_first, in_last;
  logic [7:0] in_sym;
  logic       par_done;
  logic [7:0] par_hi, par_lo;

  int checks = 0;
  int errors = 0;
  logic [7:0] buf_q [0:255];
  logic [7:0] last_hi, last_lo;

  always #4 clk = ~clk;

  rs_row_encoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_sym(in_sym), .par_done(par_done),
    .par_hi(par_hi), .par_lo(par_lo)
  );

  typedef struct packed {
    logic [2:0]      len;
    logic [3:0][7:0] d;   // d[0] sent first
    logic [7:0]      hi;
    logic [7:0]      lo;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{3'd1, {8'h00, 8'h00, 8'h00, 8'h01}, 8'h03, 8'h02},
    '{3'd1, {8'h00, 8'h00, 8'h00, 8'h80}, 8'h9D, 8'h1D},
    '{3'd2, {8'h00, 8'h00, 8'h00, 8'h01}, 8'h07, 8'h06},
    '{3'd2, {8'h00, 8'h00, 8'h01, 8'h01}, 8'h04, 8'h04},
    '{3'd3, {8'h00, 8'h00, 8'h00, 8'h00}, 8'h00, 8'h00},
    '{3'd4, {8'h00, 8'h01, 8'h00, 8'h00}, 8'h07, 8'h06},
    '{3'd1, {8'h00, 8'h00, 8'h00, 8'h00}, 8'h00, 8'h00}
  };

  // msb-first field product, own formulation
  function automatic logic [7:0] fm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      p = {p[6:0], 1'b0} ^ (p[7] ? 8'h1D : 8'h00);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  function automatic logic [7:0] finv(input logic [7:0] a);
    for (int c = 1; c < 256; c++) if (fm(a, 8'(c)) == 8'h01) return 8'(c);
    return 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_sym = 8'h00;
  endtask

  // stream buf_q[0..n-1]; gap idle cycles with junk flags before each symbol
  task automatic run_row(input int n, input int gap, input bit use_exp,
                         input logic [7:0] eh, input logic [7:0] el, input string tag);
    logic [7:0] s = 8'h00, a = 8'h00, xh, xl, p1;
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b1; in_last = 1'b1; in_sym = 8'hA5;
      end
      @(negedge clk);
      in_valid = 1'b1; in_first = (i == 0); in_last = (i == n - 1); in_sym = buf_q[i];
      s = s ^ buf_q[i];
      a = fm(a, 8'h02) ^ buf_q[i];
    end
    idle();
    // solve the two root equations directly
    p1 = fm(s ^ fm(a, 8'h04), finv(8'h03));
    xh = use_exp ? eh : p1;
    xl = use_exp ? el : (s ^ p1);
    chk(par_done == 1'b1, "R2 done after last", int'(par_done), 1);
    chk(par_hi == xh, {tag, " par_hi"}, int'(par_hi), int'(xh));
    chk(par_lo == xl, {tag, " par_lo"}, int'(par_lo), int'(xl));
    chk((s ^ par_hi ^ par_lo) == 8'h00, "R3 xor syndrome", int'(s ^ par_hi ^ par_lo), 0);
    chk((fm(a, 8'h04) ^ fm(par_hi, 8'h02) ^ par_lo) == 8'h00, "R4 alpha syndrome",
        int'(fm(a, 8'h04) ^ fm(par_hi, 8'h02) ^ par_lo), 0);
    last_hi = par_hi; last_lo = par_lo;
    idle();
    chk(par_done == 1'b0, "R2 single-cycle pulse", int'(par_done), 0);
    chk(par_hi == last_hi && par_lo == last_lo, "R8 hold after done",
        int'({par_hi, par_lo}), int'({last_hi, last_lo}));
  endtask

  task automatic load_vec(input vec_t v);
    for (int i = 0; i < 4; i++) buf_q[i] = v.d[i];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] lcg;
    rst_n = 1'b0; in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_sym = 8'h00;
    repeat (3) @(negedge clk);
    chk(par_done == 1'b0 && par_hi == 8'h00 && par_lo == 8'h00, "R1 reset state",
        int'({par_done, par_hi, par_lo}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(par_done == 1'b0 && par_hi == 8'h00 && par_lo == 8'h00, "R1 after release",
        int'({par_done, par_hi, par_lo}), 0);

    // table walk: R5 values, R9 leading zeros, R6 via nonzero predecessors
    for (int k = 0; k < NVEC; k++) begin
      load_vec(VECS[k]);
      run_row(int'(VECS[k].len), 0, 1'b1, VECS[k].hi, VECS[k].lo,
              (k == 5) ? "R9 leading zeros" : "R5 table");
    end

    // R7: idle gaps carrying junk flags and data
    load_vec(VECS[2]);
    run_row(2, 2, 1'b1, 8'h07, 8'h06, "R7 idle gaps");

    // R6: abandoned row without last, then a fresh row
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_first = (i == 0); in_last = 1'b0; in_sym = 8'h5A + 8'(i);
    end
    idle();
    chk(par_done == 1'b0 && par_hi == last_hi && par_lo == last_lo, "R8 hold mid-row",
        int'({par_done, par_hi, par_lo}), int'({1'b0, last_hi, last_lo}));
    load_vec(VECS[3]);
    run_row(2, 0, 1'b1, 8'h04, 8'h04, "R6 clear on first");

    // R10: full-length row with pseudo-random data
    lcg = 8'h3C;
    for (int i = 0; i < 253; i++) begin
      lcg = lcg * 8'd29 + 8'd71;
      buf_q[i] = lcg;
    end
    run_row(253, 0, 1'b0, 8'h00, 8'h00, "R10 253-symbol row");
    run_row(17, 1, 1'b0, 8'h00, 8'h00, "R5 mid-length row");

    // R1: reset in the middle of operation
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(par_done == 1'b0 && par_hi == 8'h00 && par_lo == 8'h00, "R1 mid-run reset",
        int'({par_done, par_hi, par_lo}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    load_vec(VECS[1]);
    run_row(1, 0, 1'b1, 8'h9D, 8'h1D, "R5 after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule